// File: doc/BRIEF.md
# Multiply-Divide Arithmetic Coprocessor

This block is a byte-addressed arithmetic helper for a small 8-bit processor. It has six operand/result bytes (MD0 to MD5), a control byte, and a command/status byte. The processor writes the operands one byte at a time and then starts an operation. The block then works for a known number of clocks. During that time it is busy and refuses writes. When it finishes, it raises a finish flag and places the results back in the same bytes.

The block offers five operations:
- unsigned 32/16 divide;
- unsigned 16/16 divide;
- 16x16 multiply;
- 32-bit logical shift in either direction;
- normalize.

Divide and multiply are started by writing an opcode to the command byte. A write to the control byte starts a shift when the count field is nonzero, and a normalize when it is zero. The results may be read back in any order. The read of the designated last byte (MD5 after a divide, MD3 after any other operation) closes the calculation.

Top module: `muldiv_unit`

## Requirements
- R1: Writing 0x01 to address 7 starts a 32/16 divide. The dividend is MD3..MD0 (MD0 lowest) and the divisor is MD5:MD4. The block is busy for exactly 17 clocks. It then leaves the quotient in MD3..MD0 and the remainder in MD5:MD4.
- R2: Writing 0x02 to address 7 starts a 16/16 divide of MD1:MD0 by MD5:MD4. The block is busy for exactly 9 clocks. It then leaves the quotient in MD1:MD0 and the remainder in MD5:MD4, and MD2/MD3 keep their values.
- R3: Writing 0x03 to address 7 starts a multiply of MD1:MD0 by MD5:MD4. The block is busy for exactly 11 clocks, and the 32-bit product then appears in MD3..MD0. Any other value written to address 7 starts nothing.
- R4: A write to address 6 with bits [4:0] = n, n nonzero, starts a shift of MD3..MD0 by n places. Bit 5 = 0 shifts left and bit 5 = 1 shifts right, and zeros fill the vacated bits. The block is busy for (n+1)/2 + 2 clocks, which is 3 to 18.
- R5: A write to address 6 with bits [4:0] = 0 starts a normalize. MD3..MD0 is shifted left k times, where k is the number of leading zeros, so that bit 7 of MD3 becomes 1. k is then written into bits [4:0] of the control byte. The block is busy for k/2 + 4 clocks, which is 4 to 19. A zero value stops at k = 31, gives a zero result and sets the error bit.
- R6: Status is read at address 7: bit 0 busy, bit 1 finish, bit 2 error, bit 3 result-open. The busy and done ports mirror bits 0 and 1. Starting any operation clears the finish flag, and the finish flag is set when the operation completes.
- R7: A divide by zero sets the error bit. It fills every result byte of that divide with 0xFF.
- R8: Any write while busy is ignored and sets the error bit. The next operation start clears the error bit.
- R9: Result-open is set at completion. It is cleared only by reading MD5 after a divide, or MD3 after a multiply, shift or normalize. Reads of other bytes leave it set.
- R10: After reset all bytes read 0x00, and busy, finish, error and result-open are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (used to detect the final result read) |
| addr | input | 3 | Register select: 0-5 MD bytes, 6 control, 7 command/status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Finish flag |
| err | output | 1 | Error flag |

## Verification
The bench sweeps operand sets that contain 0, 1, all-ones, single high bits and mixed patterns. It targets the cases where a wrong design fails visibly:
- A divider that drops the top bit of a partial remainder gives wrong results for divisors at or above 0x8000.
- A mis-sized divide by zero returns garbage instead of 0xFF bytes.
- A shifter that rotates would leak bits back in at counts near 31.
- A normalize that scans one bit too far misreports k, or the latency, for a value of 1 or 0.

Every operation is timed to the exact clock. An off-by-one in the countdown shows as busy still set, or already clear, at the boundary cycle. The bench also confirms three more behaviours: a write during busy leaves an untouched byte unchanged and raises the error bit, only the designated last byte closes the result, and the finish flag drops on the next start.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_MD   = 6;
    localparam int WORD_W   = 4 * BYTE_W;
    localparam int HALF_W   = 2 * BYTE_W;
    localparam int CNT_W    = 5;
    localparam int AMT_W    = 5;

    localparam logic [CNT_W-1:0] LAT_DIV32 = 5'd17;
    localparam logic [CNT_W-1:0] LAT_DIV16 = 5'd9;
    localparam logic [CNT_W-1:0] LAT_MUL   = 5'd11;
    localparam logic [CNT_W-1:0] SHIFT_BASE = 5'd2;
    localparam logic [CNT_W-1:0] NORM_BASE  = 5'd4;

    localparam logic [BYTE_W-1:0] CMD_DIV32 = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_DIV16 = 8'h02;
    localparam logic [BYTE_W-1:0] CMD_MUL   = 8'h03;

    typedef enum logic [2:0] {
        OP_IDLE, OP_DIV32, OP_DIV16, OP_MUL, OP_SHIFT, OP_NORM
    } op_e;

    typedef struct packed {
        logic [NUM_MD-1:0][BYTE_W-1:0] md;
        logic [BYTE_W-1:0]             ctl;
        op_e                           op;
        logic [CNT_W-1:0]              cnt;
        logic                          done;
        logic                          err;
        logic                          open;
    } mdu_state_t;

    // two shift places per clock plus fixed overhead
    function automatic logic [CNT_W-1:0] shift_lat(input logic [AMT_W-1:0] n);
        logic [AMT_W:0] half;
        half = ({1'b0, n} + 6'd1) >> 1;
        return half[CNT_W-1:0] + SHIFT_BASE;
    endfunction

    function automatic logic [CNT_W-1:0] norm_lat(input logic [AMT_W-1:0] k);
        return (k >> 1) + NORM_BASE;
    endfunction
endpackage

// File: rtl/mdu_divider.sv
module mdu_divider #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16,
    parameter int STEPS_PER_CYC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [NUM_W-1:0]          num,
    input  logic [DEN_W-1:0]          den,
    input  logic [$clog2(NUM_W+1)-1:0] nsteps,
    output logic [NUM_W-1:0]          quo,
    output logic [DEN_W-1:0]          rem
);
    localparam int SW = $clog2(NUM_W + 1);

    typedef struct packed {
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
        logic [SW-1:0]    steps;
    } div_t;

    div_t q, d;

    always_comb begin
        logic [DEN_W:0] r;
        r = '0;
        d = q;
        if (load) begin
            d.quo   = num;
            d.rem   = '0;
            d.den   = den;
            d.steps = nsteps;
        end else if (q.steps != '0) begin
            for (int i = 0; i < STEPS_PER_CYC; i++) begin
                if (d.steps != '0) begin
                    r     = {d.rem, d.quo[NUM_W-1]};
                    d.quo = {d.quo[NUM_W-2:0], 1'b0};
                    if (r >= {1'b0, d.den}) begin
                        r        = r - {1'b0, d.den};
                        d.quo[0] = 1'b1;
                    end
                    d.rem   = r[DEN_W-1:0];
                    d.steps = d.steps - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign quo = q.quo;
    assign rem = q.rem;

    // R1: restoring invariant, partial remainder stays below a nonzero divisor
    a_r1_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        (q.den != '0) |-> (q.rem < q.den));
endmodule

// File: rtl/mdu_multiplier.sv
module mdu_multiplier #(
    parameter int OP_W    = 16,
    parameter int DIGIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [2*OP_W-1:0] prod
);
    localparam int PW = 2 * OP_W;

    typedef struct packed {
        logic [PW-1:0]   acc;
        logic [PW-1:0]   mc;
        logic [OP_W-1:0] mp;
    } mul_t;

    mul_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.acc = '0;
            d.mc  = {{(PW-OP_W){1'b0}}, a};
            d.mp  = b;
        end else if (q.mp != '0) begin
            for (int j = 0; j < DIGIT_W; j++) begin
                if (q.mp[j]) d.acc = d.acc + (q.mc << j);
            end
            d.mc = q.mc << DIGIT_W;
            d.mp = q.mp >> DIGIT_W;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign prod = q.acc;

    // R3: partial sums never wrap while digits remain
    a_r3_acc_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && q.mp != '0) |=> (q.acc >= $past(q.acc)));
endmodule

// File: rtl/mdu_shifter.sv
module mdu_shifter #(
    parameter int W     = 32,
    parameter int AMT_W = 5
) (
    input  logic [W-1:0]     val,
    input  logic             dir_right,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     shifted,
    output logic [W-1:0]     norm_val,
    output logic [AMT_W-1:0] norm_amt,
    output logic             is_zero
);
    assign shifted = dir_right ? (val >> amt) : (val << amt);
    assign is_zero = (val == '0);

    always_comb begin
        logic found;
        found    = 1'b0;
        norm_amt = AMT_W'(W - 1);
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && val[i]) begin
                norm_amt = AMT_W'(W - 1 - i);
                found    = 1'b1;
            end
        end
    end

    assign norm_val = val << norm_amt;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import mdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              busy,
    output logic              done,
    output logic              err
);
    mdu_state_t s_q, s_d;

    logic [WORD_W-1:0] md_val;
    logic [HALF_W-1:0] den_val;
    logic              start_cmd, start_ctl, final_rd;
    logic              load_div, load_mul;
    logic [WORD_W-1:0] div_num;
    logic [5:0]        div_steps;
    logic [WORD_W-1:0] div_quo, mul_prod, sh_out, nm_out;
    logic [HALF_W-1:0] div_rem;
    logic [AMT_W-1:0]  nm_amt;
    logic              nm_zero;

    assign md_val  = {s_q.md[3], s_q.md[2], s_q.md[1], s_q.md[0]};
    assign den_val = {s_q.md[5], s_q.md[4]};
    assign busy    = (s_q.cnt != '0);
    assign done    = s_q.done;
    assign err     = s_q.err;

    assign start_cmd = wr_en && !busy && (addr == 3'd7) &&
                       (wdata == CMD_DIV32 || wdata == CMD_DIV16 || wdata == CMD_MUL);
    assign start_ctl = wr_en && !busy && (addr == 3'd6);
    assign load_div  = start_cmd && (wdata != CMD_MUL);
    assign load_mul  = start_cmd && (wdata == CMD_MUL);
    assign div_num   = (wdata == CMD_DIV32) ? md_val : {s_q.md[1], s_q.md[0], {HALF_W{1'b0}}};
    assign div_steps = (wdata == CMD_DIV32) ? 6'(WORD_W) : 6'(HALF_W);

    assign final_rd = rd_en && !busy && s_q.open &&
                      (((s_q.op == OP_DIV32 || s_q.op == OP_DIV16) && addr == 3'd5) ||
                       ((s_q.op == OP_MUL || s_q.op == OP_SHIFT || s_q.op == OP_NORM) && addr == 3'd3));

    mdu_divider #(.NUM_W(WORD_W), .DEN_W(HALF_W), .STEPS_PER_CYC(2)) u_div (
        .clk(clk), .rst_n(rst_n), .load(load_div), .num(div_num), .den(den_val),
        .nsteps(div_steps), .quo(div_quo), .rem(div_rem)
    );

    mdu_multiplier #(.OP_W(HALF_W), .DIGIT_W(2)) u_mul (
        .clk(clk), .rst_n(rst_n), .load(load_mul),
        .a({s_q.md[1], s_q.md[0]}), .b(den_val), .prod(mul_prod)
    );

    mdu_shifter #(.W(WORD_W), .AMT_W(AMT_W)) u_sh (
        .val(md_val), .dir_right(s_q.ctl[5]), .amt(s_q.ctl[4:0]),
        .shifted(sh_out), .norm_val(nm_out), .norm_amt(nm_amt), .is_zero(nm_zero)
    );

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (busy) begin
                s_d.err = 1'b1;
            end else if (addr < 3'd6) begin
                s_d.md[addr] = wdata;
            end else if (addr == 3'd6) begin
                s_d.ctl = wdata;
            end
        end
        if (start_cmd || start_ctl) begin
            s_d.done = 1'b0;
            s_d.err  = 1'b0;
            s_d.open = 1'b0;
        end
        if (start_cmd) begin
            case (wdata)
                CMD_DIV32: begin s_d.op = OP_DIV32; s_d.cnt = LAT_DIV32; end
                CMD_DIV16: begin s_d.op = OP_DIV16; s_d.cnt = LAT_DIV16; end
                default:   begin s_d.op = OP_MUL;   s_d.cnt = LAT_MUL;   end
            endcase
        end
        if (start_ctl) begin
            if (wdata[4:0] != '0) begin
                s_d.op  = OP_SHIFT;
                s_d.cnt = shift_lat(wdata[4:0]);
            end else begin
                s_d.op  = OP_NORM;
                s_d.cnt = norm_lat(nm_amt);
            end
        end
        if (busy) begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == 5'd1) begin
                s_d.done = 1'b1;
                s_d.open = 1'b1;
                case (s_q.op)
                    OP_DIV32: begin
                        if (den_val == '0) begin
                            s_d.md  = '1;
                            s_d.err = 1'b1;
                        end else begin
                            {s_d.md[3], s_d.md[2], s_d.md[1], s_d.md[0]} = div_quo;
                            {s_d.md[5], s_d.md[4]} = div_rem;
                        end
                    end
                    OP_DIV16: begin
                        if (den_val == '0) begin
                            {s_d.md[1], s_d.md[0]} = '1;
                            {s_d.md[5], s_d.md[4]} = '1;
                            s_d.err = 1'b1;
                        end else begin
                            {s_d.md[1], s_d.md[0]} = div_quo[HALF_W-1:0];
                            {s_d.md[5], s_d.md[4]} = div_rem;
                        end
                    end
                    OP_MUL:   {s_d.md[3], s_d.md[2], s_d.md[1], s_d.md[0]} = mul_prod;
                    OP_SHIFT: {s_d.md[3], s_d.md[2], s_d.md[1], s_d.md[0]} = sh_out;
                    OP_NORM: begin
                        {s_d.md[3], s_d.md[2], s_d.md[1], s_d.md[0]} = nm_out;
                        s_d.ctl[4:0] = nm_amt;
                        if (nm_zero) s_d.err = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
        if (final_rd) s_d.open = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.op <= OP_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (addr < 3'd6)       rdata = s_q.md[addr];
        else if (addr == 3'd6) rdata = s_q.ctl;
        else                   rdata = {4'b0, s_q.open, s_q.err, s_q.done, busy};
    end

    // R6: finish flag never coexists with an operation in flight
    a_r6_busy_excl_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !s_q.done);
    // R6: a start drops the finish flag and raises busy
    a_r6_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cmd || start_ctl) |=> (busy && !s_q.done));
    // R8: a write during an operation flags an error
    a_r8_busy_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> s_q.err);
    // R8: result bytes are frozen until the final busy cycle
    a_r8_md_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt > 5'd1) |=> $stable(s_q.md));
    // R9: an open result always belongs to a finished operation
    a_r9_open_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.open |-> s_q.done);
endmodule

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       busy, done, err;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    muldiv_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic load32(input logic [31:0] v);
        wr(3'd0, v[7:0]); wr(3'd1, v[15:8]); wr(3'd2, v[23:16]); wr(3'd3, v[31:24]);
    endtask

    task automatic load16hi(input logic [15:0] v);
        wr(3'd4, v[7:0]); wr(3'd5, v[15:8]);
    endtask

    task automatic read32(output logic [31:0] v);
        logic [7:0] b0, b1, b2, b3;
        rd(3'd0, b0); rd(3'd1, b1); rd(3'd2, b2); rd(3'd3, b3);
        v = {b3, b2, b1, b0};
    endtask

    task automatic read16hi(output logic [15:0] v);
        logic [7:0] b4, b5;
        rd(3'd4, b4); rd(3'd5, b5);
        v = {b5, b4};
    endtask

    // called right after the start write: the start edge has passed
    task automatic wait_lat(input int lat, input string tag);
        chk({tag, " busy/done after start (R6)"}, {30'd0, busy, done}, 32'd2);
        repeat (lat - 1) @(negedge clk);
        chk({tag, " busy at last cycle"}, {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk({tag, " finish after latency (R6)"}, {30'd0, busy, done}, 32'd1);
    endtask

    function automatic int clz32(input logic [31:0] v);
        for (int i = 31; i >= 0; i--) if (v[i]) return 31 - i;
        return 31;
    endfunction

    function automatic logic [15:0] v16(input int i);
        case (i)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
            3: return 16'h0003;  4: return 16'h0007;  5: return 16'h00FF;
            6: return 16'h0100;  7: return 16'h1234;  8: return 16'h7FFF;
            9: return 16'h8000; 10: return 16'hFFFE; default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [31:0] v32(input int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h0000_0001;  2: return 32'h0000_FFFF;
            3: return 32'h0001_0000;  4: return 32'h1234_5678;  5: return 32'h7FFF_FFFF;
            6: return 32'h8000_0000;  7: return 32'hDEAD_BEEF;  8: return 32'hFFFF_FFFE;
            9: return 32'h00FF_00FF; 10: return 32'h8000_0001; default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic do_mul(input logic [15:0] a, input logic [15:0] b);
        logic [31:0] p;
        wr(3'd0, a[7:0]); wr(3'd1, a[15:8]); load16hi(b);
        wr(3'd7, 8'h03);
        wait_lat(11, "R3 mul");
        read32(p);
        chk("R3 product", p, 32'(a) * 32'(b));
    endtask

    task automatic do_div32(input logic [31:0] n, input logic [15:0] dv);
        logic [31:0] q;
        logic [15:0] r;
        logic [7:0]  st;
        load32(n); load16hi(dv);
        wr(3'd7, 8'h01);
        wait_lat(17, "R1 div32");
        read32(q); read16hi(r);
        rd(3'd7, st);
        if (dv == 16'd0) begin
            chk("R7 div32 by zero quotient", q, 32'hFFFF_FFFF);
            chk("R7 div32 by zero remainder", {16'd0, r}, 32'h0000_FFFF);
            chk("R7 div32 by zero error bit", {31'd0, st[2]}, 32'd1);
        end else begin
            chk("R1 quotient", q, n / 32'(dv));
            chk("R1 remainder", {16'd0, r}, n % 32'(dv));
            chk("R1 no error", {31'd0, st[2]}, 32'd0);
        end
    endtask

    task automatic do_div16(input logic [15:0] n, input logic [15:0] dv);
        logic [31:0] q;
        logic [15:0] r;
        wr(3'd0, n[7:0]); wr(3'd1, n[15:8]); wr(3'd2, 8'hA5); wr(3'd3, 8'h5A);
        load16hi(dv);
        wr(3'd7, 8'h02);
        wait_lat(9, "R2 div16");
        read32(q); read16hi(r);
        chk("R2 MD3/MD2 untouched", {16'd0, q[31:16]}, 32'h0000_5AA5);
        if (dv == 16'd0) begin
            chk("R7 div16 by zero", {q[15:0], r}, 32'hFFFF_FFFF);
            chk("R7 div16 by zero error", {31'd0, err}, 32'd1);
        end else begin
            chk("R2 quotient", {16'd0, q[15:0]}, 32'(n / dv));
            chk("R2 remainder", {16'd0, r}, 32'(n % dv));
        end
    endtask

    task automatic do_shift(input logic [31:0] v, input logic dir, input int n);
        logic [31:0] res;
        load32(v);
        wr(3'd6, {2'b00, dir, 5'(n)});
        wait_lat((n + 1) / 2 + 2, "R4 shift");
        read32(res);
        chk("R4 shift result", res, dir ? (v >> n) : (v << n));
    endtask

    task automatic do_norm(input logic [31:0] v);
        logic [31:0] res;
        logic [7:0]  c;
        int k;
        k = clz32(v);
        load32(v);
        wr(3'd6, 8'h00);
        wait_lat(k / 2 + 4, "R5 norm");
        read32(res);
        rd(3'd6, c);
        chk("R5 normalized value", res, v << k);
        chk("R5 shift count in control", {27'd0, c[4:0]}, 32'(k));
        chk("R5 zero-value error", {31'd0, err}, (v == 32'd0) ? 32'd1 : 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), b);
            chk("R10 reset register", {24'd0, b}, 32'd0);
        end
        chk("R10 reset ports", {29'd0, busy, done, err}, 32'd0);

        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++) do_mul(v16(i), v16(j));

        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++) do_div32(v32(i), v16(j));

        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++) do_div16(v16(i), v16(j));

        for (int n = 1; n < 32; n++) begin
            do_shift(32'hDEAD_BEEF, 1'b0, n);
            do_shift(32'hDEAD_BEEF, 1'b1, n);
            do_shift(32'h8000_0001, 1'b1, n);
        end

        for (int k = 0; k < 32; k++) do_norm(32'h8000_0000 >> k);
        do_norm(32'h0001_2345);
        do_norm(32'h0000_0000);

        // R3: an unknown command code starts nothing
        wr(3'd7, 8'h07);
        chk("R3 bad opcode stays idle", {31'd0, busy}, 32'd0);

        // R8: write during busy ignored and flagged; next start clears error
        load32(32'h0000_00F0); wr(3'd4, 8'h33);
        wr(3'd6, 8'h1F);
        wr(3'd4, 8'hCC);
        repeat (18) @(negedge clk);
        rd(3'd4, b);
        chk("R8 busy write ignored", {24'd0, b}, 32'h33);
        chk("R8 busy write error", {31'd0, err}, 32'd1);
        wr(3'd6, 8'h01);
        chk("R8 start clears error", {31'd0, err}, 32'd0);
        repeat (4) @(negedge clk);

        // R9: only the designated last byte closes the result
        wr(3'd0, 8'h02); wr(3'd1, 8'h00); load16hi(16'h0003);
        wr(3'd7, 8'h03);
        repeat (11) @(negedge clk);
        rd(3'd0, b); rd(3'd1, b); rd(3'd2, b);
        rd(3'd7, b);
        chk("R9 open after partial reads", {31'd0, b[3]}, 32'd1);
        rd(3'd3, b);
        rd(3'd7, b);
        chk("R9 mul closed by MD3", {31'd0, b[3]}, 32'd0);
        load32(32'd100); load16hi(16'd7);
        wr(3'd7, 8'h01);
        repeat (17) @(negedge clk);
        read32(w);
        rd(3'd7, b);
        chk("R9 div stays open after MD3", {31'd0, b[3]}, 32'd1);
        rd(3'd5, b);
        rd(3'd7, b);
        chk("R9 div closed by MD5", {31'd0, b[3]}, 32'd0);
        chk("R6 finish flag held after reads", {31'd0, done}, 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule